// File: doc/BRIEF.md
# Overlapping Register Window File

This block is the integer register file for a processor that gives every procedure its own register window. Software addresses 32 logical registers with 5-bit numbers. Eight of them are globals that every procedure sees. The other 24 are split into three groups of eight: incoming arguments, private locals and outgoing arguments. The block maps those logical numbers onto a larger physical array through a current window pointer. A call moves the pointer forward, so the caller's outgoing group becomes the callee's incoming group. Arguments and results therefore pass between caller and callee without any copying, save or restore.

The block has two combinational read ports and one write port. The write takes effect at the rising clock edge and uses the window that was active before any call or return in the same cycle. Call and return are single-cycle strobes. The physical array holds `NWIN` windows, so only a limited call depth fits. A call that would need a window still in use, or a return with no resident caller, is refused: the pointer holds and a one-cycle flag rises. Spilling windows to memory and filling them back is done by software outside this block. The ports are plain register-file ports, with no valid/ready handshake: every read and write completes in the cycle it is presented, so there is no back-pressure.

Top module: `rwin_regfile`

## Requirements
- R1: After reset every register reads as zero, the window depth is zero and both flags are low.
- R2: Logical register 0 always reads zero, and writes to it are discarded.
- R3: Logical registers 1 to 7 (globals) name the same storage in every window.
- R4: Logical registers 16 to 23 (locals) are private to a window. A callee's write to a local does not change the caller's local with the same number.
- R5: Logical register 24+k (outgoing, k = 0..7) in a window is the same storage as logical register 8+k (incoming) in the window one call deeper, in both directions.
- R6: A lone call moves to the next window and a lone return moves back to the previous one, both modulo `NWIN`. The depth is incremented on a call and decremented on a return.
- R7: A call when the depth is already `NWIN`-2 leaves the window unchanged. It raises `ovf_o` for exactly the cycle after that edge.
- R8: A return when the depth is zero leaves the window unchanged. It raises `unf_o` for exactly the cycle after that edge.
- R9: A call and a return in the same cycle are both ignored, and neither flag rises.
- R10: A read of the register being written in the same cycle returns the new write data.
- R11: A write in the same cycle as an accepted call lands in the window that was active before the call.
- R12: The two read ports are independent, and each one can read any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Procedure call strobe |
| ret_i | input | 1 | Procedure return strobe |
| we_i | input | 1 | Write enable |
| waddr_i | input | 5 | Logical write register |
| wdata_i | input | DW | Write data |
| raddr0_i | input | 5 | Logical read register, port 0 |
| rdata0_o | output | DW | Read data, port 0 |
| raddr1_i | input | 5 | Logical read register, port 1 |
| rdata1_o | output | DW | Read data, port 1 |
| ovf_o | output | 1 | Refused call, one-cycle pulse |
| unf_o | output | 1 | Refused return, one-cycle pulse |

## Verification
The window mapping is tried with several patterns. Data is written to an outgoing register before a call and read back as an incoming register after it, which separates a correct overlap from an off-by-one window. A callee writes a local, and the caller's copy is read after the return to show that locals stay private. Globals are read from different windows to show they stay shared. A chain of calls writes a distinct marker into each window, runs into the depth limit, and then unwinds while each marker is read back; this exposes pointer-step and refusal errors that a single call cannot show. Simultaneous call and return, writes to register 0, and write-with-read in the same cycle (including during a call) tell the priority and bypass paths apart.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
  // Logical register number width and area layout (four areas of eight).
  localparam int LREG_W  = 5;
  localparam int AREA    = 8;
  localparam int NGLOB   = AREA;

  typedef enum logic [1:0] {
    AR_GLOBAL = 2'd0,
    AR_IN     = 2'd1,
    AR_LOCAL  = 2'd2,
    AR_OUT    = 2'd3
  } area_e;
endpackage

// File: rtl/rwin_map.sv
module rwin_map
  import rwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int WPW  = $clog2(NWIN),
  parameter int PW   = $clog2(NGLOB + NWIN * 2 * AREA)
) (
  input  logic [WPW-1:0]    cwp_i,
  input  logic [LREG_W-1:0] lreg_i,
  output logic [PW-1:0]     phys_o
);
  localparam int WSPAN = 2 * AREA;

  area_e area;
  int    cur_w;
  int    prev_w;
  int    idx;
  int    phys;

  assign area   = area_e'(lreg_i[LREG_W-1:LREG_W-2]);
  assign cur_w  = int'(cwp_i);
  assign prev_w = (cur_w == 0) ? NWIN - 1 : cur_w - 1;
  assign idx    = int'(lreg_i[LREG_W-3:0]);

  // Each window owns a local block followed by an outgoing block;
  // incoming registers alias the previous window's outgoing block.
  always_comb begin
    unique case (area)
      AR_GLOBAL: phys = idx;
      AR_IN:     phys = NGLOB + prev_w * WSPAN + AREA + idx;
      AR_LOCAL:  phys = NGLOB + cur_w * WSPAN + idx;
      default:   phys = NGLOB + cur_w * WSPAN + AREA + idx;
    endcase
  end

  assign phys_o = PW'(phys);
endmodule

// File: rtl/rwin_ptr.sv
module rwin_ptr #(
  parameter int NWIN = 8,
  parameter int WPW  = $clog2(NWIN)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           call_i,
  input  logic           ret_i,
  output logic [WPW-1:0] cwp_o,
  output logic           ovf_o,
  output logic           unf_o
);
  localparam int MAXD = NWIN - 2;

  logic [WPW-1:0] cwp_q;
  logic [WPW-1:0] depth_q;
  logic           do_call, do_ret, want_call, want_ret, at_top, at_bot;

  assign want_call = call_i & ~ret_i;
  assign want_ret  = ret_i & ~call_i;
  assign at_top    = (int'(depth_q) == MAXD);
  assign at_bot    = (depth_q == '0);
  assign do_call   = want_call & ~at_top;
  assign do_ret    = want_ret & ~at_bot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp_q   <= '0;
      depth_q <= '0;
      ovf_o   <= 1'b0;
      unf_o   <= 1'b0;
    end else begin
      ovf_o <= want_call & at_top;
      unf_o <= want_ret & at_bot;
      if (do_call) begin
        cwp_q   <= (int'(cwp_q) == NWIN - 1) ? '0 : cwp_q + 1'b1;
        depth_q <= depth_q + 1'b1;
      end else if (do_ret) begin
        cwp_q   <= (cwp_q == '0) ? WPW'(NWIN - 1) : cwp_q - 1'b1;
        depth_q <= depth_q - 1'b1;
      end
    end
  end

  assign cwp_o = cwp_q;

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> $stable(cwp_q));
  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf_o |-> $stable(cwp_q));
  // R6
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(depth_q) <= MAXD);
  // R9
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_o && unf_o));
endmodule

// File: rtl/rwin_store.sv
module rwin_store #(
  parameter int NPHYS = 136,
  parameter int PW    = $clog2(NPHYS),
  parameter int DW    = 32,
  parameter int NRD   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we_i,
  input  logic [PW-1:0]           wphys_i,
  input  logic [DW-1:0]           wdata_i,
  input  logic [NRD-1:0][PW-1:0]  rphys_i,
  output logic [NRD-1:0][DW-1:0]  rdata_o
);
  logic [DW-1:0] mem [NPHYS];
  logic          wr_live;

  // Physical cell 0 is the hard zero and is never written.
  assign wr_live = we_i && (wphys_i != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) mem[i] <= '0;
    end else if (wr_live) begin
      mem[wphys_i] <= wdata_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (rphys_i[p] == '0)
        rdata_o[p] = '0;
      else if (wr_live && (wphys_i == rphys_i[p]))
        rdata_o[p] = wdata_i;
      else
        rdata_o[p] = mem[rphys_i[p]];
    end

    // R2
    zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rphys_i[p] == '0) |-> (rdata_o[p] == '0));
  end

  // R2
  zero_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem[0] == '0);
endmodule

// File: rtl/rwin_regfile.sv
module rwin_regfile
  import rwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int DW   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic              we_i,
  input  logic [LREG_W-1:0] waddr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [LREG_W-1:0] raddr0_i,
  output logic [DW-1:0]     rdata0_o,
  input  logic [LREG_W-1:0] raddr1_i,
  output logic [DW-1:0]     rdata1_o,
  output logic              ovf_o,
  output logic              unf_o
);
  localparam int WPW   = $clog2(NWIN);
  localparam int NPHYS = NGLOB + NWIN * 2 * AREA;
  localparam int PW    = $clog2(NPHYS);
  localparam int NRD   = 2;

  logic [WPW-1:0]              cwp;
  logic [NRD-1:0][LREG_W-1:0]  raddr;
  logic [NRD-1:0][PW-1:0]      rphys;
  logic [NRD-1:0][DW-1:0]      rdata;
  logic [PW-1:0]               wphys;

  assign raddr[0] = raddr0_i;
  assign raddr[1] = raddr1_i;
  assign rdata0_o = rdata[0];
  assign rdata1_o = rdata[1];

  rwin_ptr #(.NWIN(NWIN), .WPW(WPW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
    .cwp_o(cwp), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  // R11: the write maps through the pointer as it stands before the edge.
  rwin_map #(.NWIN(NWIN), .WPW(WPW), .PW(PW)) u_wmap (
    .cwp_i(cwp), .lreg_i(waddr_i), .phys_o(wphys)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_rmap
    rwin_map #(.NWIN(NWIN), .WPW(WPW), .PW(PW)) u_rmap (
      .cwp_i(cwp), .lreg_i(raddr[p]), .phys_o(rphys[p])
    );
  end

  rwin_store #(.NPHYS(NPHYS), .PW(PW), .DW(DW), .NRD(NRD)) u_store (
    .clk(clk), .rst_n(rst_n), .we_i(we_i), .wphys_i(wphys),
    .wdata_i(wdata_i), .rphys_i(rphys), .rdata_o(rdata)
  );

  // R3
  global_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raddr0_i[LREG_W-1:LREG_W-2] == 2'd0) |-> (rphys[0] == PW'(raddr0_i)));
endmodule

// File: tb/rwin_regfile_test.sv
module rwin_regfile_test;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          call_i = 0, ret_i = 0, we_i = 0;
  logic [4:0]    waddr_i = 0, raddr0_i = 0, raddr1_i = 0;
  logic [DW-1:0] wdata_i = 0;
  logic [DW-1:0] rdata0_o, rdata1_o;
  logic          ovf_o, unf_o;

  always #5 clk = ~clk;

  rwin_regfile #(.NWIN(8), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
    .we_i(we_i), .waddr_i(waddr_i), .wdata_i(wdata_i),
    .raddr0_i(raddr0_i), .rdata0_o(rdata0_o),
    .raddr1_i(raddr1_i), .rdata1_o(rdata1_o),
    .ovf_o(ovf_o), .unf_o(unf_o)
  );

  typedef struct {
    int            req;
    int            kind;
    logic [DW-1:0] exp;
  } item_t;

  item_t q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 0;

  // Driver: applies one cycle of stimulus and queues what the ports must show.
  task automatic step(input logic c, input logic r, input logic w,
                      input logic [4:0] wa, input logic [DW-1:0] wd,
                      input logic [4:0] a0, input logic [DW-1:0] e0,
                      input logic [4:0] a1, input logic [DW-1:0] e1,
                      input int req, input logic eo, input logic eu);
    @(negedge clk);
    call_i = c; ret_i = r; we_i = w; waddr_i = wa; wdata_i = wd;
    raddr0_i = a0; raddr1_i = a1;
    q.push_back('{req, 0, e0});
    q.push_back('{req, 1, e1});
    q.push_back('{req, 2, DW'(eo)});
    q.push_back('{req, 3, DW'(eu)});
  endtask

  // Monitor: samples the ports late in each cycle and compares.
  initial begin
    forever begin
      @(negedge clk);
      #3;
      while (q.size() > 0) begin
        item_t it;
        logic [DW-1:0] act;
        it = q.pop_front();
        case (it.kind)
          0:       act = rdata0_o;
          1:       act = rdata1_o;
          2:       act = DW'(ovf_o);
          default: act = DW'(unf_o);
        endcase
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL R%0d port%0d actual=%h expected=%h",
                   it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset contents and flags
    step(0,0,0, 0,0, 8,0, 24,0, 1,0,0);
    step(0,0,0, 0,0, 16,0, 5,0, 1,0,0);
    // R2: register 0 ignores writes
    step(0,0,1, 0,32'h5, 0,0, 0,0, 2,0,0);
    step(0,0,0, 0,0, 0,0, 0,0, 2,0,0);
    // R10: same-cycle write then read; R12: second port
    step(0,0,1, 1,32'h11, 1,32'h11, 2,0, 10,0,0);
    step(0,0,0, 0,0, 2,0, 1,32'h11, 12,0,0);
    // setup window 0 outgoing and local
    step(0,0,1, 27,32'hA3, 0,0, 0,0, 5,0,0);
    step(0,0,1, 18,32'h12, 27,32'hA3, 0,0, 5,0,0);
    // R11: write during call lands in caller window
    step(1,0,1, 26,32'hB2, 18,32'h12, 26,32'hB2, 11,0,0);
    // R5: callee incoming sees caller outgoing
    step(0,0,0, 0,0, 10,32'hB2, 11,32'hA3, 5,0,0);
    // R4: callee local starts separate
    step(0,0,0, 0,0, 18,0, 0,0, 4,0,0);
    // R3: global visible in callee
    step(0,0,0, 0,0, 1,32'h11, 7,0, 3,0,0);
    step(0,0,1, 18,32'h77, 0,0, 0,0, 4,0,0);
    step(0,0,1, 12,32'hC4, 18,32'h77, 0,0, 4,0,0);
    // R6: return
    step(0,1,0, 0,0, 12,32'hC4, 18,32'h77, 6,0,0);
    // R4 and R5 back in caller
    step(0,0,0, 0,0, 18,32'h12, 28,32'hC4, 5,0,0);
    // R9: call with return ignored
    step(1,1,0, 0,0, 18,32'h12, 0,0, 9,0,0);
    step(0,0,0, 0,0, 18,32'h12, 28,32'hC4, 9,0,0);
    // R8: return at depth zero
    step(0,1,0, 0,0, 18,32'h12, 0,0, 8,0,0);
    step(0,0,0, 0,0, 18,32'h12, 28,32'hC4, 8,0,1);
    step(0,0,0, 0,0, 18,32'h12, 0,0, 8,0,0);
    // R6: call chain with a marker per window
    for (int d = 0; d < 6; d++)
      step(1,0,1, 16,32'h100 + 32'(d), 0,0, 0,0, 6,0,0);
    // R7: refused call, write still lands in window 6
    step(1,0,1, 16,32'h106, 0,0, 0,0, 7,0,0);
    step(0,0,0, 0,0, 16,32'h106, 0,0, 7,1,0);
    step(0,0,0, 0,0, 16,32'h106, 0,0, 7,0,0);
    // R6: unwind reading markers
    for (int d = 6; d >= 1; d--)
      step(0,1,0, 0,0, 16,32'h100 + 32'(d), 0,0, 6,0,0);
    step(0,0,0, 0,0, 16,32'h100, 18,32'h12, 6,0,0);
    step(0,0,0, 0,0, 0,0, 0,0, 6,0,0);
    @(negedge clk);
    call_i = 0; ret_i = 0; we_i = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule